// File: doc/BRIEF.md
# Register-Triggered Serial EEPROM Word Fetch

This block gives software a single 32-bit control/status register through which it can pull one 16-bit word out of an external serial EEPROM. One register write carries both the word address and a start flag. The block then drives a serial read on a four-wire EEPROM bus (chip select, clock, data out, data in). When the transfer ends, it places the returned word in the register's upper half and raises a completion flag. Software polls the register until that flag reads 1.

The start flag clears itself as soon as the serial engine takes the request. Any write that arrives while a request is pending or a transfer is running is dropped as a whole. The fetched word goes only to the register and to no other destination inside the block. The serial clock runs at the system clock divided by `2*SCK_HALF_DIV`. Chip select rests high between transfers for at least one full serial clock period.

Top module: `nvm_word_fetch`

## Requirements
- R1: After reset the register reads 0x0000_0000, chip select is high and the serial clock is low. Whenever chip select is high, the serial clock is low.
- R2: A write accepted with bit 0 = 1 latches bits 15:2 as the word address and reads back bit 0 = 1. Bit 0 returns to 0 in the cycle after the serial transfer is launched, and at that point chip select goes low.
- R3: Each transfer holds chip select low for exactly 40 serial clock rising edges. It first sends opcode 0x03 and then a 16-bit byte address equal to the word address shifted left by one, both MSB first. The data-out line is stable at every rising edge.
- R4: The last 16 bits read on the data-in line at rising edges form the word, MSB first. The word is written to bits 31:16 and bit 1 is set, both in the same cycle, 80*SCK_HALF_DIV cycles after the launch.
- R5: Bit 1 reads 0 from the cycle after an accepted start write until the word is captured.
- R6: Writes to bit 1 and to bits 31:16 have no effect. An idle write with bit 0 = 0 changes only the address field and starts no transfer.
- R7: A write that arrives while a request is pending or a transfer runs is ignored entirely: the address stays unchanged and no extra transfer occurs.
- R8: Each serial clock phase lasts exactly SCK_HALF_DIV system cycles. Chip select stays high for at least 2*SCK_HALF_DIV cycles between transfers, and a start accepted during that interval is launched after it.
- R9: The read data port always shows the current {data, address, done, start} fields, with no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Current register contents |
| spi_cs_no | output | 1 | EEPROM chip select, active low |
| spi_sck_o | output | 1 | Serial clock, idle low |
| spi_mosi_o | output | 1 | Serial data to EEPROM |
| spi_miso_i | input | 1 | Serial data from EEPROM |

## Verification
A behavioural EEPROM model returns a word computed from its address. This lets a wrong address conversion, a bit-order error or an off-by-one in the data shift show up as a data mismatch. Reads are made at address zero, at the highest address and at alternating-bit addresses, so a stuck or swapped address bit cannot go unseen.

A cycle-level model predicts all four fields every clock. It separates a correct launch and completion cycle from one that is a cycle early or late. Three further patterns are used:
- a second start write in the middle of a transfer, to separate an ignored write from a re-launched one;
- an idle write that sets the done and data bits, to separate read-only fields from writable ones;
- a start issued right at completion, to show that the chip-select gap is kept.

// File: rtl/nvm_fetch_pkg.sv
package nvm_fetch_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned CMD_W   = 8;
  localparam int unsigned ADDR_W  = 14;
  localparam int unsigned BADDR_W = 16;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned ADDR_LSB = 2;
  localparam int unsigned DATA_LSB = 16;
  localparam logic [CMD_W-1:0] READ_OP = 8'h03;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_SHIFT,
    SEQ_GAP
  } seq_state_e;
endpackage

// File: rtl/nvm_sclk_tick.sv
module nvm_sclk_tick #(
  parameter int unsigned SCK_HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clear_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(SCK_HALF_DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(SCK_HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (run_i)   cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/nvm_spi_reader.sv
module nvm_spi_reader
  import nvm_fetch_pkg::*;
#(
  parameter int unsigned SCK_HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              launch_o,
  output logic              busy_o,
  output logic              fin_o,
  output logic [DATA_W-1:0] word_o,
  output logic              spi_cs_no,
  output logic              spi_sck_o,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i
);
  localparam int unsigned TX_W    = CMD_W + BADDR_W;
  localparam int unsigned FRAME_W = TX_W + DATA_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W);
  localparam int unsigned PAD_W   = BADDR_W - ADDR_W - 1;
  localparam int unsigned GAP_MIN = 2 * SCK_HALF_DIV;
  localparam int unsigned GAP_CW  = $clog2(GAP_MIN + 1) + 1;

  seq_state_e        state_q;
  logic [TX_W-1:0]   tx_q;
  logic [DATA_W-1:0] rx_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic              sck_q, cs_n_q, gap_tick_q;
  logic              tick, last_bit;
  logic [BADDR_W-1:0] byte_addr;

  nvm_sclk_tick #(.SCK_HALF_DIV(SCK_HALF_DIV)) i_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (state_q != SEQ_IDLE),
    .clear_i (launch_o),
    .tick_o  (tick)
  );

  assign byte_addr = {{PAD_W{1'b0}}, addr_i, 1'b0};
  assign launch_o  = (state_q == SEQ_IDLE) && start_i;
  assign busy_o    = (state_q == SEQ_SHIFT);
  assign last_bit  = (bit_cnt_q == CNT_W'(FRAME_W - 1));
  assign fin_o     = busy_o && tick && sck_q && last_bit;
  assign word_o    = rx_q;
  assign spi_cs_no  = cs_n_q;
  assign spi_sck_o  = sck_q;
  assign spi_mosi_o = tx_q[TX_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SEQ_IDLE;
      tx_q       <= '0;
      rx_q       <= '0;
      bit_cnt_q  <= '0;
      sck_q      <= 1'b0;
      cs_n_q     <= 1'b1;
      gap_tick_q <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (launch_o) begin
          tx_q      <= {READ_OP, byte_addr};
          bit_cnt_q <= '0;
          cs_n_q    <= 1'b0;
          state_q   <= SEQ_SHIFT;
        end
        SEQ_SHIFT: if (tick) begin
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx_q  <= {rx_q[DATA_W-2:0], spi_miso_i};
          end else begin
            sck_q <= 1'b0;
            if (last_bit) begin
              cs_n_q     <= 1'b1;
              gap_tick_q <= 1'b0;
              state_q    <= SEQ_GAP;
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
              tx_q      <= {tx_q[TX_W-2:0], 1'b0};
            end
          end
        end
        SEQ_GAP: if (tick) begin
          if (gap_tick_q) state_q <= SEQ_IDLE;
          else            gap_tick_q <= 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // cycles spent with chip select high, saturating; checker only
  logic [GAP_CW-1:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          gap_q <= '1;
    else if (!cs_n_q)     gap_q <= '0;
    else if (gap_q != '1) gap_q <= gap_q + 1'b1;
  end

  assert_idle_lines_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sck_o);
  assert_frame_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spi_cs_no) |-> $past(bit_cnt_q) == CNT_W'(FRAME_W - 1));
  assert_cs_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spi_cs_no) |-> gap_q >= GAP_CW'(GAP_MIN));
endmodule

// File: rtl/nvm_fetch_regs.sv
module nvm_fetch_regs
  import nvm_fetch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              busy_i,
  input  logic              launch_i,
  input  logic              fin_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              start_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              start_q, done_q, accept;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              unused_wbits;

  assign unused_wbits = ^{wdata_i[REG_W-1:DATA_LSB], wdata_i[1]};
  assign accept  = we_i && !start_q && !busy_i;
  assign rdata_o = {data_q, addr_q, done_q, start_q};
  assign start_o = start_q;
  assign addr_o  = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      if (launch_i) start_q <= 1'b0;
      if (accept) begin
        addr_q <= wdata_i[ADDR_LSB +: ADDR_W];
        if (wdata_i[0]) begin
          start_q <= 1'b1;
          done_q  <= 1'b0;
        end
      end
      if (fin_i) begin
        done_q <= 1'b1;
        data_q <= word_i;
      end
    end
  end

  assert_busy_write_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (start_q || busy_i) |=> $stable(addr_q));
  assert_done_low_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !done_q);
  assert_start_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(start_q) |-> busy_i);
endmodule

// File: rtl/nvm_word_fetch.sv
module nvm_word_fetch
  import nvm_fetch_pkg::*;
#(
  parameter int unsigned SCK_HALF_DIV = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        spi_cs_no,
  output logic        spi_sck_o,
  output logic        spi_mosi_o,
  input  logic        spi_miso_i
);
  logic              start, launch, busy, fin;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] word;

  nvm_fetch_regs i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .wdata_i  (reg_wdata_i),
    .busy_i   (busy),
    .launch_i (launch),
    .fin_i    (fin),
    .word_i   (word),
    .rdata_o  (reg_rdata_o),
    .start_o  (start),
    .addr_o   (addr)
  );

  nvm_spi_reader #(.SCK_HALF_DIV(SCK_HALF_DIV)) i_reader (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .addr_i     (addr),
    .launch_o   (launch),
    .busy_o     (busy),
    .fin_o      (fin),
    .word_o     (word),
    .spi_cs_no  (spi_cs_no),
    .spi_sck_o  (spi_sck_o),
    .spi_mosi_o (spi_mosi_o),
    .spi_miso_i (spi_miso_i)
  );
endmodule

// File: tb/test_nvm_word_fetch.sv
module test_nvm_word_fetch;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cs_n, sck, mosi;
  logic        miso = 1'b0;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  nvm_word_fetch #(.SCK_HALF_DIV(HALF)) i_nvm_word_fetch (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .spi_cs_no(cs_n), .spi_sck_o(sck),
    .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  function automatic logic [15:0] mem_word(input logic [13:0] a);
    logic [31:0] t;
    t = {18'd0, a} * 32'd40503;
    return t[15:0] ^ 16'h5AC3;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---- behavioural EEPROM slave ----
  int          sbit = 0;
  logic [23:0] scmd = '0;
  int          frames = 0;
  always @(negedge cs_n) begin sbit = 0; scmd = '0; end
  always @(posedge sck) if (!cs_n) begin
    if (sbit < 24) scmd = {scmd[22:0], mosi};
    sbit++;
  end
  always @(negedge sck) if (!cs_n && sbit >= 24 && sbit < 40)
    miso = mem_word(scmd[14:1])[15 - (sbit - 24)];

  // ---- cycle-level reference model ----
  int          cyc = 0;
  bit          m_out = 0;
  logic        m_start = 0, m_done = 0;
  logic [13:0] m_addr = '0, m_laddr = '0;
  logic [15:0] m_data = '0;
  int          launch_at = -1, done_at = -1, last_done = -100000;
  int          m_frames = 0;

  always @(posedge clk) begin
    if (rst_ni) begin
      bit acc;
      cyc++;
      acc = we && !m_out;
      if (cyc == launch_at) m_start = 1'b0;
      if (m_out && cyc == done_at) begin
        m_out = 0; m_done = 1'b1; m_data = mem_word(m_laddr); last_done = cyc;
      end
      if (acc) begin
        m_addr = wdata[15:2];
        if (wdata[0]) begin
          m_out = 1; m_start = 1'b1; m_done = 1'b0; m_laddr = wdata[15:2];
          launch_at = (cyc + 1 > last_done + 2*HALF + 1) ? cyc + 1 : last_done + 2*HALF + 1;
          done_at = launch_at + 80*HALF;
          m_frames++;
        end
      end
    end
  end

  // ---- per-clock comparison and serial timing checks ----
  int   hcnt = 0, csh = 0;
  logic prev_sck = 0, prev_cs = 1;
  always @(negedge clk) if (rst_ni) begin
    check(rdata[0] == m_start, "R2 start bit", rdata[0], m_start);
    check(rdata[1] == m_done, "R5/R4 done bit", rdata[1], m_done);
    check(rdata[15:2] == m_addr, "R7/R6 address field", rdata[15:2], m_addr);
    check(rdata[31:16] == m_data, "R4/R9 data field", rdata[31:16], m_data);
    hcnt++;
    if (!cs_n && prev_cs) begin
      hcnt = 0;
      if (frames > 0) check(csh >= 2*HALF, "R8 cs high gap", csh, 2*HALF);
      csh = 0;
    end
    if (cs_n) csh++;
    if (sck != prev_sck) begin
      check(hcnt == HALF, "R8 sck phase length", hcnt, HALF);
      hcnt = 0;
    end
    if (cs_n && !prev_cs) begin
      frames++;
      check(sbit == 40, "R3 rising edges per frame", sbit, 40);
      check(scmd[23:16] == 8'h03, "R3 opcode", scmd[23:16], 8'h03);
      check(scmd[15:0] == {1'b0, m_laddr, 1'b0}, "R3 byte address", scmd[15:0], {1'b0, m_laddr, 1'b0});
    end
    if (cs_n) check(!sck, "R1 sck low while deselected", sck, 0);
    prev_sck = sck;
    prev_cs  = cs_n;
  end

  task automatic wr(input logic [31:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (rdata[1]) break;
    end
  endtask

  task automatic do_read(input logic [13:0] a);
    wr({16'h0, a, 2'b01});
    wait_done();
    check(rdata[31:16] == mem_word(a), "R4 returned word", rdata[31:16], mem_word(a));
    repeat (3*HALF + 4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rdata == 32'h0, "R1 reset register", rdata, 0);
    check(cs_n == 1'b1, "R1 reset cs", cs_n, 1);
    check(sck == 1'b0, "R1 reset sck", sck, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    do_read(14'h0000);
    do_read(14'h3FFF);
    do_read(14'h1555);
    do_read(14'h2AAA);

    // R6: idle write touching done and data bits, no start
    wr({16'hFFFF, 14'h0123, 2'b10});
    repeat (4*HALF) @(negedge clk);
    check(rdata[31:16] == mem_word(14'h2AAA), "R6 data unchanged", rdata[31:16], mem_word(14'h2AAA));
    check(rdata[1] == 1'b1, "R6 done unchanged", rdata[1], 1);
    check(frames == 4, "R6 no transfer started", frames, 4);

    // R7: second start mid-transfer
    wr({16'h0, 14'h0777, 2'b01});
    repeat (20) @(negedge clk);
    wr({16'hABCD, 14'h0999, 2'b11});
    wait_done();
    check(rdata[15:2] == 14'h0777, "R7 address kept", rdata[15:2], 14'h0777);
    check(rdata[31:16] == mem_word(14'h0777), "R7 word of first request", rdata[31:16], mem_word(14'h0777));

    // R8: start issued right at completion
    wr({16'h0, 14'h0042, 2'b01});
    wait_done();
    check(rdata[31:16] == mem_word(14'h0042), "R8 back-to-back word", rdata[31:16], mem_word(14'h0042));
    repeat (3*HALF + 4) @(negedge clk);
    check(frames == m_frames, "R7 transfer count", frames, m_frames);
    check(frames == 6, "R7 total transfers", frames, 6);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule